// File: doc/BRIEF.md
# Immediate-Operand Execution Unit

This unit carries out the immediate-format instructions of a 32-bit load-store processor. Each cycle it can accept one instruction, given as a 6-bit opcode, the value read from the source register, the index of the destination register and the 16-bit constant carried in the instruction word. The five operations it handles are add, signed set-less-than, bitwise AND, bitwise OR and load-upper. Each operation widens the 16-bit constant in its own way before using it.

One cycle after an accepted instruction, the unit presents a registered 32-bit result, the destination index and a write enable for the register file. The write enable stays low for opcodes the unit does not handle and for a destination of register 0. A load-upper followed by an OR into the same register builds any 32-bit constant in two instructions. The result of the first can be fed straight back as the source of the second.

Top module: `imm_exec_unit`

## Requirements
- R1: While rst_ni is low, valid_o and wr_en_o are 0, and result_o and dst_idx_o are 0.
- R2: Opcode 8 (add) yields rs plus the constant sign-extended to 32 bits. The sum wraps modulo 2^32 and raises no trap.
- R3: Opcode 10 (set-less-than) yields 1 when rs is less than the sign-extended constant, both taken as signed two's-complement values. Otherwise it yields 0. Bits 31:1 are always 0.
- R4: Opcode 12 (AND) yields rs AND the constant zero-extended to 32 bits.
- R5: Opcode 13 (OR) yields rs OR the constant zero-extended to 32 bits.
- R6: Opcode 15 (load-upper) yields the constant in bits 31:16 and zeros in bits 15:0. The source value is ignored.
- R7: For every cycle with valid_i high, valid_o is high on the next cycle. The result, write enable and destination index of that instruction appear in that same cycle.
- R8: Any other opcode, when valid, gives valid_o high, wr_en_o low and result_o 0.
- R9: A valid instruction whose destination index is 0 gives wr_en_o low.
- R10: A cycle with valid_i low gives valid_o and wr_en_o low on the next cycle. In that cycle result_o and dst_idx_o keep their previous values.
- R11: A load-upper with constant H, followed by an OR into the same register with constant L, whose source is the load-upper result, yields {H, L}.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Instruction present this cycle |
| opcode_i | input | 6 | Operation code |
| rs_val_i | input | 32 | Source register value |
| rt_idx_i | input | 5 | Destination register index |
| imm_i | input | 16 | Instruction constant |
| valid_o | output | 1 | Result valid |
| wr_en_o | output | 1 | Register file write enable |
| dst_idx_o | output | 5 | Destination register index |
| result_o | output | 32 | Operation result |

## Verification
Two things can occur in the same cycle. The load-upper result leaves the output register in the same cycle that the dependent OR enters the unit, with its source taken from that very output. The bench provokes this by sampling result_o at the falling edge and driving it back as rs_val_i for the OR at once. It then compares the following output with the 32-bit constant it assembles itself. A second overlap is checked in constrained random runs with back-to-back valid instructions. There, a destination of 0 or an unknown opcode must mask the write enable while the result register still takes the new value.

// File: rtl/imm_exec_pkg.sv
package imm_exec_pkg;
  localparam int unsigned OP_W = 6;

  localparam logic [OP_W-1:0] OPC_ADD = 6'd8;
  localparam logic [OP_W-1:0] OPC_SLT = 6'd10;
  localparam logic [OP_W-1:0] OPC_AND = 6'd12;
  localparam logic [OP_W-1:0] OPC_OR  = 6'd13;
  localparam logic [OP_W-1:0] OPC_LUI = 6'd15;

  typedef enum logic [2:0] {
    KIND_NONE,
    KIND_ADD,
    KIND_SLT,
    KIND_AND,
    KIND_OR,
    KIND_LUI
  } op_kind_e;
endpackage

// File: rtl/imm_decode.sv
module imm_decode
  import imm_exec_pkg::*;
(
  input  logic [OP_W-1:0] opcode_i,
  output op_kind_e        kind_o,
  output logic            sign_ext_o,
  output logic            known_o
);
  always_comb begin
    kind_o     = KIND_NONE;
    sign_ext_o = 1'b0;
    unique case (opcode_i)
      OPC_ADD: begin kind_o = KIND_ADD; sign_ext_o = 1'b1; end
      OPC_SLT: begin kind_o = KIND_SLT; sign_ext_o = 1'b1; end
      OPC_AND: kind_o = KIND_AND;
      OPC_OR:  kind_o = KIND_OR;
      OPC_LUI: kind_o = KIND_LUI;
      default: kind_o = KIND_NONE;
    endcase
    known_o = (kind_o != KIND_NONE);
  end
endmodule

// File: rtl/imm_extend.sv
module imm_extend #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [IMM_W-1:0]  imm_i,
  input  logic              sign_ext_i,
  output logic [DATA_W-1:0] ext_o
);
  localparam int unsigned FILL_W = DATA_W - IMM_W;

  logic fill_bit;
  assign fill_bit = sign_ext_i & imm_i[IMM_W-1];
  assign ext_o    = {{FILL_W{fill_bit}}, imm_i};
endmodule

// File: rtl/imm_alu.sv
module imm_alu
  import imm_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  op_kind_e          kind_i,
  input  logic [DATA_W-1:0] rs_i,
  input  logic [DATA_W-1:0] ext_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic [DATA_W-1:0] res_o
);
  localparam int unsigned UP_SHIFT = DATA_W - IMM_W;

  logic              lt;
  logic [DATA_W-1:0] upper;

  assign lt    = $signed(rs_i) < $signed(ext_i);
  assign upper = {imm_i, {UP_SHIFT{1'b0}}};

  always_comb begin
    unique case (kind_i)
      KIND_ADD: res_o = rs_i + ext_i;
      KIND_SLT: res_o = {{(DATA_W-1){1'b0}}, lt};
      KIND_AND: res_o = rs_i & ext_i;
      KIND_OR:  res_o = rs_i | ext_i;
      KIND_LUI: res_o = upper;
      default:  res_o = '0;
    endcase
  end
endmodule

// File: rtl/imm_exec_unit.sv
module imm_exec_unit
  import imm_exec_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              valid_i,
  input  logic [OP_W-1:0]   opcode_i,
  input  logic [DATA_W-1:0] rs_val_i,
  input  logic [IDX_W-1:0]  rt_idx_i,
  input  logic [IMM_W-1:0]  imm_i,
  output logic              valid_o,
  output logic              wr_en_o,
  output logic [IDX_W-1:0]  dst_idx_o,
  output logic [DATA_W-1:0] result_o
);
  op_kind_e          kind;
  logic              sign_ext;
  logic              known;
  logic [DATA_W-1:0] ext_imm;
  logic [DATA_W-1:0] alu_res;

  imm_decode u_dec (
    .opcode_i   (opcode_i),
    .kind_o     (kind),
    .sign_ext_o (sign_ext),
    .known_o    (known)
  );

  imm_extend #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
    .imm_i      (imm_i),
    .sign_ext_i (sign_ext),
    .ext_o      (ext_imm)
  );

  imm_alu #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_alu (
    .kind_i (kind),
    .rs_i   (rs_val_i),
    .ext_i  (ext_imm),
    .imm_i  (imm_i),
    .res_o  (alu_res)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o   <= 1'b0;
      wr_en_o   <= 1'b0;
      dst_idx_o <= '0;
      result_o  <= '0;
    end else begin
      valid_o <= valid_i;
      wr_en_o <= valid_i && known && (rt_idx_i != '0);
      if (valid_i) begin
        dst_idx_o <= rt_idx_i;
        result_o  <= alu_res;
      end
    end
  end

  assert_valid_latency_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i |=> valid_o);
  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !valid_i |=> (!valid_o && !wr_en_o && $stable(result_o)));
  assert_zero_dst_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && rt_idx_i == '0) |=> !wr_en_o);
  assert_bad_op_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i != OPC_ADD && opcode_i != OPC_SLT && opcode_i != OPC_AND
     && opcode_i != OPC_OR && opcode_i != OPC_LUI) |=> (!wr_en_o && result_o == '0));
  assert_slt_bool_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OPC_SLT) |=> (result_o[DATA_W-1:1] == '0));
  assert_lui_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && opcode_i == OPC_LUI) |=> (result_o[DATA_W-IMM_W-1:0] == '0));
endmodule

// File: tb/tb_imm_exec_unit.sv
`timescale 1ns/1ps
module tb_imm_exec_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        valid_i = 1'b0;
  logic [5:0]  opcode_i = '0;
  logic [31:0] rs_val_i = '0;
  logic [4:0]  rt_idx_i = '0;
  logic [15:0] imm_i = '0;
  logic        valid_o, wr_en_o;
  logic [4:0]  dst_idx_o;
  logic [31:0] result_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [31:0] exp_res = '0;
  logic [4:0]  exp_dst = '0;

  always #5 clk_i = ~clk_i;

  imm_exec_unit dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .valid_i(valid_i), .opcode_i(opcode_i),
    .rs_val_i(rs_val_i), .rt_idx_i(rt_idx_i), .imm_i(imm_i),
    .valid_o(valid_o), .wr_en_o(wr_en_o), .dst_idx_o(dst_idx_o), .result_o(result_o)
  );

  function automatic logic [31:0] model_res(input logic [5:0] op, input logic [31:0] rs,
                                            input logic [15:0] imm);
    logic [31:0] sx;
    logic [31:0] zx;
    sx = {{16{imm[15]}}, imm};
    zx = {16'h0, imm};
    case (op)
      6'd8:    return rs + sx;
      6'd10:   return ($signed(rs) < $signed(sx)) ? 32'd1 : 32'd0;
      6'd12:   return rs & zx;
      6'd13:   return rs | zx;
      6'd15:   return {imm, 16'h0};
      default: return 32'd0;
    endcase
  endfunction

  function automatic bit op_known(input logic [5:0] op);
    return op == 6'd8 || op == 6'd10 || op == 6'd12 || op == 6'd13 || op == 6'd15;
  endfunction

  function automatic string op_tag(input logic [5:0] op);
    case (op)
      6'd8:    return "R2";
      6'd10:   return "R3";
      6'd12:   return "R4";
      6'd13:   return "R5";
      6'd15:   return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // drive at falling edge, check one cycle later at the next falling edge
  task automatic issue(input bit v, input logic [5:0] op, input logic [31:0] rs,
                       input logic [4:0] rt, input logic [15:0] imm, input string tag);
    bit exp_wr;
    valid_i = v; opcode_i = op; rs_val_i = rs; rt_idx_i = rt; imm_i = imm;
    if (v) begin
      exp_res = model_res(op, rs, imm);
      exp_dst = rt;
      exp_wr  = op_known(op) && rt != 5'd0;
    end else begin
      exp_wr = 1'b0;
    end
    @(negedge clk_i);
    chk(v ? "R7" : "R10", {31'd0, valid_o}, {31'd0, v});
    chk(!v ? "R10" : (rt == 0 ? "R9" : (op_known(op) ? "R7" : "R8")),
        {31'd0, wr_en_o}, {31'd0, exp_wr});
    chk(v ? tag : "R10", result_o, exp_res);
    chk(v ? "R7" : "R10", {27'd0, dst_idx_o}, {27'd0, exp_dst});
  endtask

  initial begin
    logic [31:0] hi;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk_i);
    chk("R1", {30'd0, valid_o, wr_en_o}, 32'd0);
    chk("R1", result_o, 32'd0);
    chk("R1", {27'd0, dst_idx_o}, 32'd0);
    rst_ni = 1'b1;
    @(negedge clk_i);

    issue(1, 6'd8,  32'h7FFF_FFFF, 5'd3, 16'h0001, "R2");
    issue(1, 6'd8,  32'h0000_0000, 5'd4, 16'hFFFF, "R2");
    issue(1, 6'd10, 32'hFFFF_FFFF, 5'd5, 16'h0000, "R3");
    issue(1, 6'd10, 32'h0000_0005, 5'd5, 16'h8000, "R3");
    issue(1, 6'd10, 32'h8000_0000, 5'd6, 16'h7FFF, "R3");
    issue(1, 6'd12, 32'hFFFF_FFFF, 5'd7, 16'h8001, "R4");
    issue(1, 6'd13, 32'h1234_0000, 5'd8, 16'hFFFF, "R5");
    issue(1, 6'd15, 32'hDEAD_BEEF, 5'd9, 16'hABCD, "R6");
    issue(1, 6'h23, 32'h1111_1111, 5'd9, 16'h1234, "R8");
    issue(1, 6'd8,  32'h0000_0010, 5'd0, 16'h0001, "R9");
    issue(0, 6'd15, 32'h0,         5'd1, 16'hFFFF, "R10");

    // back-to-back: OR consumes the load-upper result in the cycle it appears
    issue(1, 6'd15, 32'h0, 5'd8, 16'hAAAA, "R6");
    hi = result_o;
    issue(1, 6'd13, hi, 5'd8, 16'h5555, "R11");
    chk("R11", result_o, 32'hAAAA_5555);

    for (int i = 0; i < 400; i++) begin
      logic [5:0] op;
      case ($urandom % 7)
        0: op = 6'd8;
        1: op = 6'd10;
        2: op = 6'd12;
        3: op = 6'd13;
        4: op = 6'd15;
        5: op = 6'($urandom);
        default: op = 6'd8;
      endcase
      issue(($urandom % 5) != 0, op, $urandom, 5'($urandom), 16'($urandom), op_tag(op));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule